// File: doc/BRIEF.md
# Configurable Audio Frame Serializer (I2S / TDM)

The block turns parallel audio samples into a frame-sync line and a serial data line, one bit per cycle of its clock, which is the bit clock. Two framing families share one counting engine. In word-select mode the sync line holds one level for the whole first channel and the opposite level for the second channel. This covers I2S, left-justified and right-justified framing. In pulse mode the sync line carries a pulse at the start of every frame, and the frame holds up to sixteen time slots. This covers both DSP variants and multi-slot TDM.

Static configuration inputs set the framing. They select the mode, the sample size, the bit clocks per period, the slot width, and the distance from a slot boundary to the sample MSB. They also set the sync polarity with an inversion option, the sync pulse width, the bit-clock edge on which the outputs change, the slot count and a per-slot enable mask. The configuration may only change while soft reset is held. Samples arrive on a valid/ready pair. Ready is a single-cycle request raised at the first bit of every enabled slot, and the sample must already be valid in that cycle.

Top module: `tdm_serial_tx`

## Requirements
- R1: With `cfg_pulse_mode`=0 a frame is two periods of `cfg_period_m1`+1 bit clocks each. The sync output sits at the active level during the first period (channel 0) and at the inverse level during the second (channel 1).
- R2: The period field holds the bit clocks per period minus one. In pulse mode one period is the whole frame. The output for frame position n appears after the (n+1)-th rising edge that follows the edge that cleared the counters.
- R3: With `cfg_pulse_mode`=1 the sync output is at the active level for the first `cfg_sync_width`+1 bit clocks of each frame and inactive for the rest.
- R4: Within each slot, data is zero for the first `cfg_offset` bit clocks. The sample then follows MSB first, and every bit after its LSB up to the slot end is 0.
- R5: `cfg_size` 00 selects 8-bit samples, 01 selects 16-bit and 10 or 11 selects 32-bit. A sample is taken from the low bits of `s_data`, and the bits above the size have no effect on the output.
- R6: The active sync level is `cfg_sync_high` XOR `cfg_sync_flip`.
- R7: With `cfg_fall_edge`=0 the outputs change on the rising clock edge. With `cfg_fall_edge`=1 they carry the same sequence but change on the following falling edge, half a cycle later.
- R8: In pulse mode slot i covers frame bits i×(`cfg_slot_m1`+1) onward, and slots above `cfg_slots_m1` carry zeros. In word-select mode the slots are the two channels, 0 and 1. A slot whose bit in `cfg_slot_en` is 0 outputs zeros and takes no sample.
- R9: `s_ready` is high for exactly one cycle, at the first bit of each enabled slot. One sample is taken per enabled slot, in slot order. If `s_valid` is low in that cycle, the slot carries zeros and the sticky `underflow_o` is set.
- R10: A cycle of `soft_rst` clears the counters, the shift register and `underflow_o`, drives data and sync to 0 on the next cycle, and restarts at frame position 0. The configuration is kept.
- R11: While `rst_n` is low, `sdata_o`, `sync_o` and `underflow_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous restart of counters, shifter and flag |
| cfg_pulse_mode | input | 1 | 0 word-select framing, 1 pulse framing |
| cfg_size | input | 2 | Sample size code (00=8, 01=16, 1x=32) |
| cfg_period_m1 | input | CNT_W | Bit clocks per period minus one |
| cfg_slot_m1 | input | CNT_W | Pulse mode: bit clocks per slot minus one |
| cfg_offset | input | CNT_W | Bit clocks from slot start to sample MSB |
| cfg_sync_high | input | 1 | Format polarity, 1 = active high |
| cfg_sync_flip | input | 1 | Inverts the active sync level |
| cfg_sync_width | input | SYNCW_W | Pulse width minus one |
| cfg_fall_edge | input | 1 | Outputs change on the falling edge |
| cfg_slots_m1 | input | $clog2(MAX_SLOTS) | Pulse mode: slot count minus one |
| cfg_slot_en | input | MAX_SLOTS | Per-slot enable mask |
| s_valid | input | 1 | Sample valid |
| s_ready | output | 1 | Sample request at slot start |
| s_data | input | DATA_W | Sample, right-aligned |
| sync_o | output | 1 | Frame sync line |
| sdata_o | output | 1 | Serial data line |
| underflow_o | output | 1 | Sticky missing-sample flag |

## Verification
The bench builds the block with its defaults: 32-bit samples, sixteen slots, a 10-bit counter and the falling-edge path present. Those values make 16-slot masks, all three sample sizes and both edge choices reachable. For each configuration it predicts every serial bit and sync level arithmetically from the slot index, the offset and a running sample count. It sweeps size, offset and edge over a two-slot pulse frame and over both channel framings. It also restarts mid-frame through soft reset and withholds samples to raise the underflow flag.

// File: rtl/tdm_tx_pkg.sv
`timescale 1ns/1ps
package tdm_tx_pkg;
   typedef enum logic [1:0] {
      SZ_8   = 2'b00,
      SZ_16  = 2'b01,
      SZ_32  = 2'b10,
      SZ_32X = 2'b11
   } size_code_e;

   function automatic int unsigned size_bits(input logic [1:0] code);
      case (size_code_e'(code))
         SZ_8:    return 8;
         SZ_16:   return 16;
         default: return 32;
      endcase
   endfunction
endpackage

// File: rtl/tdm_tx_frame_ctr.sv
`timescale 1ns/1ps
module tdm_tx_frame_ctr #(
   parameter int CNT_W  = 10,
   parameter int SIDX_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              pulse_mode,
   input  logic [CNT_W-1:0]  period_m1,
   input  logic [CNT_W-1:0]  slot_m1,
   output logic [CNT_W-1:0]  fpos,
   output logic [CNT_W-1:0]  spos,
   output logic [SIDX_W-1:0] sidx,
   output logic              slot_start
);
   localparam logic [SIDX_W-1:0] SIDX_TOP = '1;

   logic [CNT_W-1:0] slen_m1;
   logic             frame_end;
   logic             slot_end;

   assign slen_m1    = pulse_mode ? slot_m1 : period_m1;
   assign frame_end  = (fpos >= period_m1);
   assign slot_end   = (spos >= slen_m1);
   assign slot_start = (spos == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fpos <= '0;
         spos <= '0;
         sidx <= '0;
      end else if (clr) begin
         fpos <= '0;
         spos <= '0;
         sidx <= '0;
      end else if (frame_end) begin
         fpos <= '0;
         spos <= '0;
         sidx <= pulse_mode ? '0 : {{(SIDX_W-1){1'b0}}, ~sidx[0]};
      end else begin
         fpos <= fpos + 1'b1;
         if (slot_end) begin
            spos <= '0;
            if (sidx != SIDX_TOP) sidx <= sidx + 1'b1;
         end else begin
            spos <= spos + 1'b1;
         end
      end
   end

   AST_FPOS_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n || clr)
      fpos <= period_m1);                                               // R2
   AST_TWO_CHANNELS: assert property (@(posedge clk) disable iff (!rst_n || clr)
      !pulse_mode |-> (sidx <= SIDX_W'(1)));                            // R1
endmodule

// File: rtl/tdm_tx_slot_gate.sv
`timescale 1ns/1ps
module tdm_tx_slot_gate #(
   parameter int MAX_SLOTS = 16,
   parameter int SLOT_IW   = 4,
   parameter int SIDX_W    = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 pulse_mode,
   input  logic [SLOT_IW-1:0]   slots_m1,
   input  logic [MAX_SLOTS-1:0] slot_en,
   input  logic [SIDX_W-1:0]    sidx,
   input  logic                 slot_start,
   input  logic                 s_valid,
   output logic                 s_ready,
   output logic                 take,
   output logic                 underflow
);
   logic used;
   logic enabled;
   logic need;

   assign used    = pulse_mode ? (sidx <= {1'b0, slots_m1}) : (sidx <= SIDX_W'(1));
   assign enabled = used && slot_en[sidx[SLOT_IW-1:0]];
   assign need    = slot_start && enabled && !clr;
   assign s_ready = need;
   assign take    = need && s_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             underflow <= 1'b0;
      else if (clr)           underflow <= 1'b0;
      else if (need && !s_valid) underflow <= 1'b1;
   end

   AST_UNDERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n || clr)
      underflow |=> underflow);                                         // R9
   AST_MISS_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n || clr)
      (s_ready && !s_valid) |=> underflow);                             // R9
endmodule

// File: rtl/tdm_tx_bit_shifter.sv
`timescale 1ns/1ps
module tdm_tx_bit_shifter #(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              load,
   input  logic              take,
   input  logic [DATA_W-1:0] word,
   input  logic [CNT_W-1:0]  spos,
   input  logic [CNT_W-1:0]  offset,
   output logic              bit_q
);
   logic [DATA_W-1:0] sh_q;
   logic [DATA_W-1:0] sh_d;
   logic [DATA_W-1:0] src;
   logic              bit_d;
   logic              in_win;

   assign src    = take ? word : '0;
   assign in_win = (spos >= offset);

   always_comb begin
      if (load) begin
         if (in_win) begin
            bit_d = src[DATA_W-1];
            sh_d  = src << 1;
         end else begin
            bit_d = 1'b0;
            sh_d  = src;
         end
      end else if (in_win) begin
         bit_d = sh_q[DATA_W-1];
         sh_d  = sh_q << 1;
      end else begin
         bit_d = 1'b0;
         sh_d  = sh_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         bit_q <= 1'b0;
      end else if (clr) begin
         sh_q  <= '0;
         bit_q <= 1'b0;
      end else begin
         sh_q  <= sh_d;
         bit_q <= bit_d;
      end
   end

   AST_MISS_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n || clr)
      (load && !take) |=> !bit_q);                                      // R9
   AST_PRE_OFFSET_ZERO: assert property (@(posedge clk) disable iff (!rst_n || clr)
      (spos < offset) |=> !bit_q);                                      // R4
endmodule

// File: rtl/tdm_tx_edge_out.sv
`timescale 1ns/1ps
module tdm_tx_edge_out #(
   parameter bit NEG_EDGE_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fall_edge,
   input  logic d_sync,
   input  logic d_data,
   output logic sync_o,
   output logic data_o
);
   generate
      if (NEG_EDGE_EN) begin : g_dual
         logic n_sync;
         logic n_data;
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) begin
               n_sync <= 1'b0;
               n_data <= 1'b0;
            end else begin
               n_sync <= d_sync;
               n_data <= d_data;
            end
         end
         assign sync_o = fall_edge ? n_sync : d_sync;
         assign data_o = fall_edge ? n_data : d_data;
      end else begin : g_rise
         logic unused_fall;
         assign unused_fall = fall_edge;
         assign sync_o = d_sync;
         assign data_o = d_data;
      end
   endgenerate
endmodule

// File: rtl/tdm_serial_tx.sv
`timescale 1ns/1ps
module tdm_serial_tx #(
   parameter int DATA_W      = 32,
   parameter int MAX_SLOTS   = 16,
   parameter int CNT_W       = 10,
   parameter int SYNCW_W     = 8,
   parameter bit NEG_EDGE_EN = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         soft_rst,
   input  logic                         cfg_pulse_mode,
   input  logic [1:0]                   cfg_size,
   input  logic [CNT_W-1:0]             cfg_period_m1,
   input  logic [CNT_W-1:0]             cfg_slot_m1,
   input  logic [CNT_W-1:0]             cfg_offset,
   input  logic                         cfg_sync_high,
   input  logic                         cfg_sync_flip,
   input  logic [SYNCW_W-1:0]           cfg_sync_width,
   input  logic                         cfg_fall_edge,
   input  logic [$clog2(MAX_SLOTS)-1:0] cfg_slots_m1,
   input  logic [MAX_SLOTS-1:0]         cfg_slot_en,
   input  logic                         s_valid,
   output logic                         s_ready,
   input  logic [DATA_W-1:0]            s_data,
   output logic                         sync_o,
   output logic                         sdata_o,
   output logic                         underflow_o
);
   import tdm_tx_pkg::*;

   localparam int SLOT_IW = $clog2(MAX_SLOTS);
   localparam int SIDX_W  = SLOT_IW + 1;

   generate
      if (DATA_W < 32) begin : g_bad_data_w
         $error("DATA_W must hold a 32-bit sample");
      end
      if (MAX_SLOTS < 2 || (MAX_SLOTS & (MAX_SLOTS - 1)) != 0) begin : g_bad_slots
         $error("MAX_SLOTS must be a power of two of at least 2");
      end
      if (CNT_W < SYNCW_W || CNT_W < 6) begin : g_bad_cnt_w
         $error("CNT_W must cover the sync width field and a 32-bit slot");
      end
   endgenerate

   logic [CNT_W-1:0]  fpos;
   logic [CNT_W-1:0]  spos;
   logic [SIDX_W-1:0] sidx;
   logic              slot_start;
   logic              take;
   logic              bit_q;
   logic [DATA_W-1:0] word;
   logic              act_lvl;
   logic              sync_d;
   logic              sync_q;

   tdm_tx_frame_ctr #(.CNT_W(CNT_W), .SIDX_W(SIDX_W)) u_ctr (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (soft_rst),
      .pulse_mode (cfg_pulse_mode),
      .period_m1  (cfg_period_m1),
      .slot_m1    (cfg_slot_m1),
      .fpos       (fpos),
      .spos       (spos),
      .sidx       (sidx),
      .slot_start (slot_start)
   );

   tdm_tx_slot_gate #(.MAX_SLOTS(MAX_SLOTS), .SLOT_IW(SLOT_IW), .SIDX_W(SIDX_W)) u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (soft_rst),
      .pulse_mode (cfg_pulse_mode),
      .slots_m1   (cfg_slots_m1),
      .slot_en    (cfg_slot_en),
      .sidx       (sidx),
      .slot_start (slot_start),
      .s_valid    (s_valid),
      .s_ready    (s_ready),
      .take       (take),
      .underflow  (underflow_o)
   );

   // left-align the sample so its MSB sits at the top of the shifter
   assign word = s_data << (DATA_W - size_bits(cfg_size));

   tdm_tx_bit_shifter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (soft_rst),
      .load   (slot_start),
      .take   (take),
      .word   (word),
      .spos   (spos),
      .offset (cfg_offset),
      .bit_q  (bit_q)
   );

   assign act_lvl = cfg_sync_high ^ cfg_sync_flip;

   always_comb begin
      if (cfg_pulse_mode) sync_d = (fpos <= CNT_W'(cfg_sync_width)) ? act_lvl : ~act_lvl;
      else                sync_d = sidx[0] ? ~act_lvl : act_lvl;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sync_q <= 1'b0;
      else if (soft_rst) sync_q <= 1'b0;
      else               sync_q <= sync_d;
   end

   tdm_tx_edge_out #(.NEG_EDGE_EN(NEG_EDGE_EN)) u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .fall_edge (cfg_fall_edge),
      .d_sync    (sync_q),
      .d_data    (bit_q),
      .sync_o    (sync_o),
      .data_o    (sdata_o)
   );

   AST_PULSE_AT_START: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
      (cfg_pulse_mode && fpos == '0) |=> (sync_q == (cfg_sync_high ^ cfg_sync_flip))); // R3
   AST_SRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (!bit_q && !sync_q && !underflow_o));                // R10
endmodule

// File: tb/tdm_serial_tx_bench.sv
`timescale 1ns/1ps
module tdm_serial_tx_bench;
   localparam int DATA_W = 32;
   localparam int MAXS   = 16;
   localparam int CNT_W  = 10;
   localparam int SW_W   = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic soft_rst = 1'b0;
   logic pm = 1'b0;
   logic [1:0] sz = 2'b00;
   logic [CNT_W-1:0] per_m1 = '0, slt_m1 = '0, off = '0;
   logic hi = 1'b0, flp = 1'b0, fall = 1'b0;
   logic [SW_W-1:0] wid = '0;
   logic [3:0] nsl_m1 = '0;
   logic [MAXS-1:0] mask = '0;
   logic s_valid = 1'b0;
   logic s_ready;
   logic [DATA_W-1:0] s_data;
   logic sync_o, sdata_o, underflow_o;

   int k = 0;
   int kbase = 0;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   function automatic logic [31:0] pat(int idx);
      return (32'(idx) * 32'h9E37_79B9) ^ 32'hC3A5_0F96;
   endfunction

   assign s_data = pat(k);
   always @(posedge clk) if (s_valid && s_ready) k <= k + 1;

   tdm_serial_tx u_tdm_serial_tx (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .cfg_pulse_mode(pm), .cfg_size(sz), .cfg_period_m1(per_m1),
      .cfg_slot_m1(slt_m1), .cfg_offset(off), .cfg_sync_high(hi),
      .cfg_sync_flip(flp), .cfg_sync_width(wid), .cfg_fall_edge(fall),
      .cfg_slots_m1(nsl_m1), .cfg_slot_en(mask), .s_valid(s_valid),
      .s_ready(s_ready), .s_data(s_data), .sync_o(sync_o),
      .sdata_o(sdata_o), .underflow_o(underflow_o)
   );

   task automatic chk(input string tag, input logic act, input logic exp, input int pos);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s pos=%0d actual=%b expected=%b t=%0t", tag, pos, act, exp, $time);
      end
   endtask

   task automatic chk_int(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int ssize();
      return (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
   endfunction
   function automatic int flen();
      return pm ? int'(per_m1) + 1 : 2 * (int'(per_m1) + 1);
   endfunction
   function automatic int nslots();
      return pm ? int'(nsl_m1) + 1 : 2;
   endfunction
   function automatic int active_per_frame();
      int a = 0;
      for (int j = 0; j < nslots(); j++) a += int'(mask[j]);
      return a;
   endfunction

   // R4 R5 R8: expected serial bit at frame position n
   function automatic logic exp_data(int n);
      int r = n % flen();
      int f = n / flen();
      int slen = pm ? int'(slt_m1) + 1 : int'(per_m1) + 1;
      int si = r / slen;
      int sp = r % slen;
      int w;
      int b;
      logic [31:0] v;
      if (si >= nslots() || !mask[si] || !s_valid) return 1'b0;
      w = kbase + f * active_per_frame();
      for (int j = 0; j < si; j++) w += int'(mask[j]);
      if (sp < int'(off)) return 1'b0;
      b = sp - int'(off);
      if (b >= ssize()) return 1'b0;
      v = pat(w);
      return v[ssize() - 1 - b];
   endfunction

   // R1 R3 R6: expected sync level at frame position n
   function automatic logic exp_sync(int n);
      int r = n % flen();
      logic a = hi ^ flp;
      if (pm) return (r <= int'(wid)) ? a : ~a;
      return (r < int'(per_m1) + 1) ? a : ~a;
   endfunction

   task automatic run_case(input logic c_pm, input logic [1:0] c_sz, input int c_per,
                           input int c_slot, input int c_off, input logic c_hi,
                           input logic c_flp, input int c_wid, input logic c_fall,
                           input int c_nsl, input int c_mask, input int frames,
                           input logic c_valid);
      int n_tot;
      string stag;
      @(negedge clk);
      pm = c_pm; sz = c_sz; per_m1 = CNT_W'(c_per); slt_m1 = CNT_W'(c_slot);
      off = CNT_W'(c_off); hi = c_hi; flp = c_flp; wid = SW_W'(c_wid);
      fall = c_fall; nsl_m1 = 4'(c_nsl); mask = MAXS'(c_mask); s_valid = c_valid;
      soft_rst = 1'b1;
      @(posedge clk);
      #1;
      soft_rst = 1'b0;
      kbase = k;
      chk("R10 flag cleared by soft reset", underflow_o, 1'b0, -1);
      if (!fall) chk("R10 data quiet after soft reset", sdata_o, 1'b0, -1);
      n_tot = frames * flen();
      stag = pm ? "R3 R6 sync" : "R1 R6 sync";
      for (int n = 0; n < n_tot; n++) begin
         @(posedge clk);
         #2;
         if (fall) begin
            chk("R7 data held until falling edge", sdata_o, (n == 0) ? 1'b0 : exp_data(n - 1), n);
            chk("R7 sync held until falling edge", sync_o, (n == 0) ? 1'b0 : exp_sync(n - 1), n);
         end else begin
            chk("R7 data on rising edge", sdata_o, exp_data(n), n);
         end
         #5;
         chk("R2 R4 R5 R8 data", sdata_o, exp_data(n), n);
         chk(stag, sync_o, exp_sync(n), n);
      end
      chk_int("R9 samples taken per run", k - kbase, c_valid ? frames * active_per_frame() : 0);
      chk("R9 underflow flag", underflow_o, (!c_valid && active_per_frame() > 0) ? 1'b1 : 1'b0, -1);
      repeat (5) @(posedge clk);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      chk("R11 reset data", sdata_o, 1'b0, -1);
      chk("R11 reset sync", sync_o, 1'b0, -1);
      chk("R11 reset flag", underflow_o, 1'b0, -1);
      @(negedge clk);
      rst_n = 1'b1;

      // word-select framings: I2S, left-justified, right-justified with inverted frame
      run_case(0, 2'b01, 15, 0, 1, 0, 0, 0, 0, 0, 'h3, 3, 1);
      run_case(0, 2'b00, 11, 0, 0, 1, 0, 0, 0, 0, 'h3, 3, 1);
      run_case(0, 2'b01, 23, 0, 8, 1, 1, 0, 1, 0, 'h3, 3, 1);
      run_case(0, 2'b10, 31, 0, 1, 0, 0, 0, 1, 0, 'h1, 2, 1);
      run_case(0, 2'b11, 31, 0, 0, 1, 0, 0, 0, 0, 'h2, 2, 1);
      // pulse framings: DSP offsets 1 and 0, TDM masks, widths, idle tail
      run_case(1, 2'b01, 31, 15, 1, 1, 0, 0, 0, 1, 'h3, 3, 1);
      run_case(1, 2'b10, 63, 31, 0, 1, 0, 3, 1, 1, 'h3, 2, 1);
      run_case(1, 2'b00, 35, 7, 0, 1, 0, 2, 1, 3, 'hB, 3, 1);
      run_case(1, 2'b00, 127, 7, 1, 1, 1, 1, 0, 15, 'h5A3C, 2, 1);
      run_case(1, 2'b01, 63, 19, 4, 0, 0, 5, 0, 2, 'h7, 2, 1);
      // sweep of size, offset and edge over a two-slot pulse frame
      for (int s = 0; s < 3; s++)
         for (int o = 0; o < 3; o++)
            for (int e = 0; e < 2; e++)
               run_case(1, 2'(s), 63, 31, o, 1, 0, o, 1'(e), 1, 'h3, 2, 1);
      // missing samples, then recovery
      run_case(0, 2'b01, 15, 0, 1, 0, 0, 0, 0, 0, 'h3, 2, 0);
      run_case(1, 2'b00, 35, 7, 0, 1, 0, 2, 0, 3, 'hB, 2, 0);
      run_case(0, 2'b00, 11, 0, 0, 1, 0, 0, 0, 0, 'h3, 2, 1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule